// File: doc/BRIEF.md
# Nonvolatile Store/Recall Sequencer

This block decides when a volatile memory array is copied into its nonvolatile backing cells and when it is restored from them. A store can come from three places: a rising edge on the supply-low comparator input, a software store command, or an external hardware store request. A software recall command copies the nonvolatile contents back into the array. Every store runs an erase phase and then a program phase. Recall runs as a single timed phase. All phase lengths are parameters counted in clock cycles.

While an operation runs, the block drives an active-low busy pin (open-drain style: low means busy) and sets a status bit. It also raises an access-inhibit signal that the memory port uses to refuse reads and writes. A write strobe from the memory port marks the array as modified. A hardware store request is acted on only when the array has been modified. The block has no data stream, so every pin is a plain level or one-cycle pulse, and the block applies no back-pressure.

Top module: `nv_seq_ctrl`

## Requirements
- R1: A store drives `erase_on` high for exactly ERASE_CYC consecutive cycles. It then drives `prog_on` high for exactly PROG_CYC consecutive cycles. At most one of `erase_on`, `prog_on` and `restore_stb` is high in any cycle.
- R2: After reset, `busy_n` is 1 and `stat_rdy` is 0. While a store or recall runs, `busy_n` is 0 and `stat_rdy` is 1. Both return to idle values when the operation ends.
- R3: `mem_inhibit` is 1 in every cycle of a store or recall. It is also 1 in any cycle where `pwr_low` is 1, in the same cycle and with no clock delay.
- R4: A 0-to-1 transition of `pwr_low` seen while idle starts a store on the next clock edge. No prior write is needed for this store.
- R5: A `sw_store` pulse while idle starts a store, even when nothing has been written.
- R6: A `hw_store_req` pulse while idle starts a store only if the array is modified. Otherwise it is ignored, and `stat_rdy` stays 0.
- R7: The modified flag is set by a `wr_req` pulse only while `mem_inhibit` is 0. It is cleared when a store or recall completes. A write attempted during an operation does not set it.
- R8: A `sw_recall` pulse while idle runs a recall. The recall holds busy for RECALL_CYC cycles, keeps `erase_on` and `prog_on` low, and pulses `restore_stb` in its last busy cycle only.
- R9: `sw_store`, `hw_store_req` and `sw_recall` are ignored while busy. A `pwr_low` rising edge seen while busy is latched, and a store starts after one idle cycle.
- R10: If a store trigger and `sw_recall` occur in the same idle cycle, only the store runs and the recall is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pwr_low | input | 1 | Supply-low comparator output (1 = below switch threshold) |
| sw_store | input | 1 | Software store command pulse |
| hw_store_req | input | 1 | External hardware store request pulse |
| sw_recall | input | 1 | Software recall command pulse |
| wr_req | input | 1 | Array write strobe from the memory port |
| busy_n | output | 1 | Busy pin, 0 while an operation runs |
| stat_rdy | output | 1 | Status busy bit, 1 while an operation runs |
| mem_inhibit | output | 1 | Blocks array reads and writes |
| erase_on | output | 1 | Erase phase active |
| prog_on | output | 1 | Program phase active |
| restore_stb | output | 1 | One-cycle strobe that restores the array |

## Verification
Two collisions are provoked on purpose.

The first is a supply-low rising edge that arrives in the middle of a software store. The bench then expects two complete stores in sequence and nothing more.

The second is a software store and a recall pulsed in the same idle cycle. The scoreboard must see exactly one store and no recall.

A write strobe pulsed during a running store must leave the flag clear. This is judged when a later hardware request produces no operation, observed at `stat_rdy`.

// File: rtl/nvs_pkg.sv
package nvs_pkg;
  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_ERASE  = 2'd1,
    PH_PROG   = 2'd2,
    PH_RECALL = 2'd3
  } nvs_phase_e;
endpackage

// File: rtl/nvs_trig_arb.sv
module nvs_trig_arb (
  input  logic clk,
  input  logic rst_n,
  input  logic pwr_low,
  input  logic sw_store,
  input  logic hw_store_req,
  input  logic sw_recall,
  input  logic wr_req,
  input  logic inhibit,
  input  logic idle,
  input  logic op_done,
  output logic start_store,
  output logic start_recall
);
  logic pf_q;
  logic pf_pend;
  logic dirty;
  logic pf_rise;
  logic store_req;

  assign pf_rise      = pwr_low & ~pf_q;
  assign store_req    = pf_rise | pf_pend | sw_store | (hw_store_req & dirty);
  assign start_store  = idle & store_req;
  assign start_recall = idle & sw_recall & ~store_req;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pf_q    <= 1'b0;
      pf_pend <= 1'b0;
      dirty   <= 1'b0;
    end else begin
      pf_q <= pwr_low;
      if (idle)         pf_pend <= 1'b0;
      else if (pf_rise) pf_pend <= 1'b1;
      if (op_done)                dirty <= 1'b0;
      else if (wr_req & ~inhibit) dirty <= 1'b1;
    end
  end
endmodule

// File: rtl/nvs_phase_timer.sv
module nvs_phase_timer
  import nvs_pkg::*;
#(
  parameter int ERASE_CYC  = 64,
  parameter int PROG_CYC   = 128,
  parameter int RECALL_CYC = 96
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_store,
  input  logic start_recall,
  output logic idle,
  output logic busy,
  output logic erase_on,
  output logic prog_on,
  output logic restore_stb,
  output logic op_done
);
  localparam int MAX_EP = (ERASE_CYC > PROG_CYC) ? ERASE_CYC : PROG_CYC;
  localparam int MAX_C  = (MAX_EP > RECALL_CYC) ? MAX_EP : RECALL_CYC;
  localparam int CW     = $clog2(MAX_C + 1);

  nvs_phase_e   phase;
  logic [CW-1:0] cnt;
  logic          last;

  assign last        = (cnt == '0);
  assign idle        = (phase == PH_IDLE);
  assign busy        = ~idle;
  assign erase_on    = (phase == PH_ERASE);
  assign prog_on     = (phase == PH_PROG);
  assign restore_stb = (phase == PH_RECALL) & last;
  assign op_done     = ((phase == PH_PROG) | (phase == PH_RECALL)) & last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= PH_IDLE;
      cnt   <= '0;
    end else begin
      case (phase)
        PH_IDLE: begin
          if (start_store) begin
            phase <= PH_ERASE;
            cnt   <= CW'(ERASE_CYC - 1);
          end else if (start_recall) begin
            phase <= PH_RECALL;
            cnt   <= CW'(RECALL_CYC - 1);
          end
        end
        PH_ERASE: begin
          if (last) begin
            phase <= PH_PROG;
            cnt   <= CW'(PROG_CYC - 1);
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        default: begin
          if (last) phase <= PH_IDLE;
          else      cnt   <= cnt - 1'b1;
        end
      endcase
    end
  end
endmodule

// File: rtl/nv_seq_ctrl.sv
module nv_seq_ctrl #(
  parameter int ERASE_CYC  = 64,
  parameter int PROG_CYC   = 128,
  parameter int RECALL_CYC = 96
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pwr_low,
  input  logic sw_store,
  input  logic hw_store_req,
  input  logic sw_recall,
  input  logic wr_req,
  output logic busy_n,
  output logic stat_rdy,
  output logic mem_inhibit,
  output logic erase_on,
  output logic prog_on,
  output logic restore_stb
);
  logic idle;
  logic busy;
  logic op_done;
  logic start_store;
  logic start_recall;

  assign mem_inhibit = busy | pwr_low;
  assign busy_n      = ~busy;
  assign stat_rdy    = busy;

  nvs_trig_arb u_arb (
    .clk          (clk),
    .rst_n        (rst_n),
    .pwr_low      (pwr_low),
    .sw_store     (sw_store),
    .hw_store_req (hw_store_req),
    .sw_recall    (sw_recall),
    .wr_req       (wr_req),
    .inhibit      (mem_inhibit),
    .idle         (idle),
    .op_done      (op_done),
    .start_store  (start_store),
    .start_recall (start_recall)
  );

  nvs_phase_timer #(
    .ERASE_CYC  (ERASE_CYC),
    .PROG_CYC   (PROG_CYC),
    .RECALL_CYC (RECALL_CYC)
  ) u_timer (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_store  (start_store),
    .start_recall (start_recall),
    .idle         (idle),
    .busy         (busy),
    .erase_on     (erase_on),
    .prog_on      (prog_on),
    .restore_stb  (restore_stb),
    .op_done      (op_done)
  );
endmodule

// File: rtl/nvs_checker.sv
module nvs_checker (
  input logic clk,
  input logic rst_n,
  input logic pwr_low,
  input logic busy_n,
  input logic stat_rdy,
  input logic mem_inhibit,
  input logic erase_on,
  input logic prog_on,
  input logic restore_stb
);
  a_r1_one_phase: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({erase_on, prog_on, restore_stb}));

  a_r1_erase_then_prog: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(erase_on) |-> prog_on);

  a_r3_busy_inhibits: assert property (@(posedge clk) disable iff (!rst_n)
    (erase_on || prog_on || restore_stb) |-> (mem_inhibit && !busy_n && stat_rdy));

  a_r4_pf_starts_store: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(pwr_low) && !stat_rdy) |=> erase_on);

  a_r8_strobe_ends_op: assert property (@(posedge clk) disable iff (!rst_n)
    restore_stb |=> !stat_rdy);
endmodule

bind nv_seq_ctrl nvs_checker u_nvs_checker (
  .clk         (clk),
  .rst_n       (rst_n),
  .pwr_low     (pwr_low),
  .busy_n      (busy_n),
  .stat_rdy    (stat_rdy),
  .mem_inhibit (mem_inhibit),
  .erase_on    (erase_on),
  .prog_on     (prog_on),
  .restore_stb (restore_stb)
);

// File: tb/nv_seq_ctrl_tb_top.sv
module nv_seq_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int EC = 5;
  localparam int PC = 7;
  localparam int RC = 4;
  localparam int STORE_CODE  = 1000000 + EC * 10000 + PC * 100;
  localparam int RECALL_CODE = 2000000 + RC * 10 + 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pwr_low = 1'b0, sw_store = 1'b0, hw_store_req = 1'b0, sw_recall = 1'b0, wr_req = 1'b0;
  logic busy_n, stat_rdy, mem_inhibit, erase_on, prog_on, restore_stb;

  int tests = 0;
  int fails = 0;
  int exp_q[$];
  bit done = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  nv_seq_ctrl #(.ERASE_CYC(EC), .PROG_CYC(PC), .RECALL_CYC(RC)) dut_i (
    .clk(clk), .rst_n(rst_n), .pwr_low(pwr_low), .sw_store(sw_store),
    .hw_store_req(hw_store_req), .sw_recall(sw_recall), .wr_req(wr_req),
    .busy_n(busy_n), .stat_rdy(stat_rdy), .mem_inhibit(mem_inhibit),
    .erase_on(erase_on), .prog_on(prog_on), .restore_stb(restore_stb)
  );

  task automatic check(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic pulse(ref logic sig);
    @(negedge clk) sig = 1'b1;
    @(negedge clk) sig = 1'b0;
  endtask

  task automatic wait_idle();
    int quiet = 0;
    while (quiet < 3) begin
      @(negedge clk);
      if (stat_rdy) quiet = 0; else quiet++;
    end
  endtask

  // Monitor: rebuilds each operation from the phase pins and compares with the scoreboard
  int e_n = 0, p_n = 0, r_n = 0, s_n = 0;
  bit in_op = 1'b0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (stat_rdy) begin
        in_op = 1'b1;
        if (busy_n !== 1'b0 || mem_inhibit !== 1'b1) begin
          fails++;
          $display("FAIL R2/R3 busy pins actual=%b%b expected=01", busy_n, mem_inhibit);
        end
        if (erase_on) e_n++;
        else if (prog_on) p_n++;
        else r_n++;
        if (restore_stb) s_n++;
      end else if (in_op) begin
        int kind;
        int code;
        kind = (e_n > 0) ? 1 : 2;
        code = kind * 1000000 + e_n * 10000 + p_n * 100 + r_n * 10 + s_n;
        if (exp_q.size() == 0) check("R9/R10 unexpected op", code, 0);
        else check("R1/R8 op shape", code, exp_q.pop_front());
        in_op = 1'b0; e_n = 0; p_n = 0; r_n = 0; s_n = 0;
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=hang expected=finish");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R2 reset state
    check("R2 busy_n reset", busy_n, 1);
    check("R2 stat_rdy reset", stat_rdy, 0);
    check("R3 inhibit idle", mem_inhibit, 0);

    // R6 hw request ignored while clean
    pulse(hw_store_req);
    wait_idle();
    check("R6 clean hw ignored", stat_rdy, 0);

    // R5 software store runs while clean
    exp_q.push_back(STORE_CODE);
    pulse(sw_store);
    wait_idle();

    // R7 accepted write, R6 hw store runs when dirty
    pulse(wr_req);
    exp_q.push_back(STORE_CODE);
    pulse(hw_store_req);
    wait_idle();
    // R7 flag cleared by completion
    pulse(hw_store_req);
    wait_idle();
    check("R7 cleared after store", stat_rdy, 0);

    // R7 write during busy not accepted
    exp_q.push_back(STORE_CODE);
    pulse(sw_store);
    repeat (2) @(negedge clk);
    pulse(wr_req);
    wait_idle();
    pulse(hw_store_req);
    wait_idle();
    check("R7 write while busy ignored", stat_rdy, 0);

    // R8 recall, also clears the flag
    pulse(wr_req);
    exp_q.push_back(RECALL_CODE);
    pulse(sw_recall);
    wait_idle();
    pulse(hw_store_req);
    wait_idle();
    check("R7 cleared after recall", stat_rdy, 0);

    // R3 immediate inhibit and R4 power-fail store
    exp_q.push_back(STORE_CODE);
    @(negedge clk) pwr_low = 1'b1;
    #1 check("R3 inhibit same cycle", mem_inhibit, 1);
    @(negedge clk);
    check("R4 store started", erase_on, 1);
    wait_idle();
    pwr_low = 1'b0;
    wait_idle();
    check("R4 falling edge no op", stat_rdy, 0);

    // R9 power-fail latched during store, other commands ignored
    exp_q.push_back(STORE_CODE);
    exp_q.push_back(STORE_CODE);
    pulse(sw_store);
    repeat (2) @(negedge clk);
    pwr_low = 1'b1;
    pulse(sw_recall);
    pulse(sw_store);
    wait_idle();
    pwr_low = 1'b0;
    check("R9 all expected ops seen", exp_q.size(), 0);

    // R10 store and recall in same idle cycle
    exp_q.push_back(STORE_CODE);
    @(negedge clk) begin sw_store = 1'b1; sw_recall = 1'b1; end
    @(negedge clk) begin sw_store = 1'b0; sw_recall = 1'b0; end
    wait_idle();
    check("R10 recall dropped", exp_q.size(), 0);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule